// File: doc/BRIEF.md
# USB Suspend/Resume Controller

This block is the power-management corner of a low-speed USB device. It watches the sampled D+/D- lines for the end-of-packet pattern that accompanies every frame keep-alive. It counts the clock cycles since the last one. When the bus stays silent longer than a programmable number of cycles, the block enters suspend. It reports this on a status output that lowers the transceiver's power, and it also raises a suspend interrupt flag.

While suspended, the block looks for a host resume, which shows as the line moving from J to K. When it sees one, it asserts a wake output and raises a resume interrupt flag. Firmware can also wake the bus itself. It holds a send-resume control bit, and the block drives K onto the bus for as long as that bit stays set. Firmware ends the suspended period by writing the suspend bit to zero.

A small register port reaches two registers. The first is an interrupt-flag register, which also holds two endpoint event flags fed by strobes from the packet logic. The second is a control register with the suspend bit, the send-resume bit and the interrupt mask bits. The interrupt output is the OR of the enabled flags.

The controller is a four-state machine:
- **ACTIVE**: counts idle cycles.
- **SUSPEND**: waits for a resume from either side.
- **WAKE**: a host resume has been seen.
- **DRIVE_K**: the device is signalling resume.

Its transitions are:
- **ACTIVE→SUSPEND**: the idle limit is reached.
- **SUSPEND→ACTIVE**: the suspend bit is cleared.
- **SUSPEND→DRIVE_K**: send-resume is set.
- **SUSPEND→WAKE**: a J-to-K change is seen.
- **WAKE→ACTIVE**: the suspend bit is cleared.
- **DRIVE_K→SUSPEND**: send-resume is cleared.
- **DRIVE_K→ACTIVE**: the suspend bit is cleared.

Top module: `usb_lp_ctrl`

## Requirements
- R1: In ACTIVE, once IDLE_CYCLES consecutive cycles pass with no activity, the block enters suspend. It sets `susp_o`, control bit 0 reads 1, and interrupt flag bit 2 (suspend) is set.
- R2: Line states are decoded as J = D+ low with D- high, K = D+ high with D- low, and SE0 = both low. An SE0 followed by J counts as activity and restarts the idle count, so regular keep-alives prevent suspend.
- R3: While suspended, a J-to-K change on the inputs sets interrupt flag bit 3 (resume). It also asserts `wake_o`, which stays high until the suspend bit is cleared. A J-to-K change in ACTIVE does not set bit 3.
- R4: Writing the control register (address 1) with bit 0 = 0 while suspended returns the block to ACTIVE. `susp_o` and `wake_o` go low.
- R5: While suspended with control bit 1 (send-resume) set, the block drives K: `drv_oe`=1, `dp_o`=1 and `dm_o`=0. Clearing the bit stops the drive, and the block stays suspended.
- R6: Setting send-resume while in ACTIVE does not enable the drivers.
- R7: Writing 1 to control bit 0 while in ACTIVE has no effect; only the idle timer sets the suspend bit.
- R8: `ep0_evt` sets interrupt flag bit 0 and `inep_evt` sets flag bit 1. Flags clear when 1 is written to them at address 0. A set and a clear in the same cycle leave the flag set.
- R9: `irq` is the OR of the enabled flags. Control bits 2, 3 and 4 mask flags 1, 2 and 3 respectively (1 = disabled), and flag 0 is always enabled. Register bits without a function read 0.
- R10: After reset, all flags and control bits read 0, and `susp_o`, `wake_o`, `drv_oe` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | Sampled D+ line |
| dm_i | input | 1 | Sampled D- line |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| drv_oe | output | 1 | Line driver enable |
| ep0_evt | input | 1 | Endpoint 0 event strobe |
| inep_evt | input | 1 | IN endpoint event strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = interrupt flags, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| susp_o | output | 1 | Suspend status for the transceiver |
| wake_o | output | 1 | Wake request after a host resume |

## Verification
Two events can land in the same cycle: an endpoint event strobe setting a flag, and a firmware write-1-to-clear of that same flag. The bench provokes this with a vector that raises `ep0_evt` in the same cycle as a write of 1 to flag bit 0. It then reads the flag register: the flag must still read 1, and `irq` must stay high. A second vector then clears the flag with no competing strobe, which shows that the clear path itself works.

// File: rtl/usb_lp_pkg.sv
package usb_lp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2,
        LS_SE1 = 2'd3
    } line_t;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_SUSPEND = 2'd1,
        ST_WAKE    = 2'd2,
        ST_DRIVE_K = 2'd3
    } pm_state_t;

    localparam int NFLAGS    = 4;
    localparam int FLAG_EP0  = 0;
    localparam int FLAG_INEP = 1;
    localparam int FLAG_SUSP = 2;
    localparam int FLAG_RES  = 3;
    localparam int NMASK     = NFLAGS - 1;

    function automatic line_t decode_line(input logic dp, input logic dm);
        line_t r;
        unique case ({dp, dm})
            2'b00:   r = LS_SE0;
            2'b01:   r = LS_J;
            2'b10:   r = LS_K;
            default: r = LS_SE1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usb_lp_line.sv
module usb_lp_line
    import usb_lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dp_i,
    input  logic dm_i,
    output logic activity,
    output logic j_to_k
);

    line_t cur_q;
    line_t prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= LS_J;
            prev_q <= LS_J;
        end else begin
            cur_q  <= decode_line(dp_i, dm_i);
            prev_q <= cur_q;
        end
    end

    // End of packet / keep-alive: SE0 followed by idle J
    assign activity = (prev_q == LS_SE0) && (cur_q == LS_J);
    // Resume signalling edge from the host
    assign j_to_k   = (prev_q == LS_J) && (cur_q == LS_K);

endmodule

// File: rtl/usb_lp_idle.sv
module usb_lp_idle #(
    parameter int IDLE_CYCLES = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic activity,
    output logic done
);

    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || activity) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && !activity && (cnt_q == LIMIT);

    // R2: activity while counting restarts the count
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && activity) |=> (cnt_q == '0));

endmodule

// File: rtl/usb_lp_fsm.sv
module usb_lp_fsm
    import usb_lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_done,
    input  logic j_to_k,
    input  logic send_res,
    input  logic susp_clr,
    output logic count_en,
    output logic susp_o,
    output logic wake_o,
    output logic drv_oe,
    output logic dp_o,
    output logic dm_o,
    output logic susp_set,
    output logic res_set
);

    pm_state_t st_q;
    pm_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ACTIVE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE: begin
                if (idle_done) st_d = ST_SUSPEND;
            end
            ST_SUSPEND: begin
                if (susp_clr)      st_d = ST_ACTIVE;
                else if (send_res) st_d = ST_DRIVE_K;
                else if (j_to_k)   st_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (susp_clr) st_d = ST_ACTIVE;
            end
            ST_DRIVE_K: begin
                if (susp_clr)       st_d = ST_ACTIVE;
                else if (!send_res) st_d = ST_SUSPEND;
            end
            default: st_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        count_en = 1'b0;
        susp_o   = 1'b1;
        wake_o   = 1'b0;
        drv_oe   = 1'b0;
        dp_o     = 1'b0;
        dm_o     = 1'b0;
        susp_set = 1'b0;
        res_set  = 1'b0;
        unique case (st_q)
            ST_ACTIVE: begin
                count_en = 1'b1;
                susp_o   = 1'b0;
                susp_set = idle_done;
            end
            ST_SUSPEND: begin
                res_set = j_to_k && !susp_clr && !send_res;
            end
            ST_WAKE: begin
                wake_o = 1'b1;
            end
            ST_DRIVE_K: begin
                drv_oe = 1'b1;
                dp_o   = 1'b1;
                dm_o   = 1'b0;
            end
            default: begin
                susp_o = 1'b0;
            end
        endcase
    end

    // R1: suspend is only entered from a finished idle count
    a_r1_entry_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_ACTIVE && $past(st_q) == ST_ACTIVE) |-> $past(idle_done));

    // R5: K is only driven while the send-resume request was present
    a_r5_k_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        drv_oe |-> $past(send_res));

    // R4: clearing the suspend bit always leads back to ACTIVE
    a_r4_clear_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_clr && st_q != ST_ACTIVE) |=> (st_q == ST_ACTIVE));

endmodule

// File: rtl/usb_lp_regs.sv
module usb_lp_regs
    import usb_lp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          ep0_evt,
    input  logic          inep_evt,
    input  logic          susp_set,
    input  logic          res_set,
    input  logic          suspended,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          send_res,
    output logic          susp_clr
);

    localparam int CTRL_SUSP  = 0;
    localparam int CTRL_SRES  = 1;
    localparam int CTRL_MASK0 = 2;

    logic [NFLAGS-1:0] flag_q;
    logic [NFLAGS-1:0] flag_set;
    logic [NFLAGS-1:0] flag_clr;
    logic [NMASK-1:0]  mask_q;
    logic              sres_q;
    logic              wr_flags;
    logic              wr_ctrl;
    logic [NFLAGS-1:0] enable;

    assign wr_flags = reg_we && !reg_addr;
    assign wr_ctrl  = reg_we &&  reg_addr;

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_EP0]  = ep0_evt;
        flag_set[FLAG_INEP] = inep_evt;
        flag_set[FLAG_SUSP] = susp_set;
        flag_set[FLAG_RES]  = res_set;
        flag_clr            = wr_flags ? reg_wdata[NFLAGS-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
            sres_q <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (wr_ctrl) begin
                mask_q <= reg_wdata[CTRL_MASK0 +: NMASK];
                sres_q <= reg_wdata[CTRL_SRES];
            end
        end
    end

    assign susp_clr = wr_ctrl && !reg_wdata[CTRL_SUSP];
    assign send_res = sres_q;

    assign enable = {~mask_q, 1'b1};
    assign irq    = |(flag_q & enable);

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[NFLAGS-1:0] = flag_q;
        end else begin
            reg_rdata[CTRL_SUSP]             = suspended;
            reg_rdata[CTRL_SRES]             = sres_q;
            reg_rdata[CTRL_MASK0 +: NMASK]   = mask_q;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[DW-1:CTRL_MASK0+NMASK];

    // R8: an event strobe wins over a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_evt |=> flag_q[FLAG_EP0]);

    // R8: a clear with no competing strobe empties the flag
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && reg_wdata[FLAG_EP0] && !ep0_evt) |=> !flag_q[FLAG_EP0]);

    // R3: the resume flag only rises after the state machine reports it
    a_r3_res_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[FLAG_RES]) |-> $past(res_set));

endmodule

// File: rtl/usb_lp_ctrl.sv
module usb_lp_ctrl #(
    parameter int IDLE_CYCLES = 18000,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_i,
    input  logic          dm_i,
    output logic          dp_o,
    output logic          dm_o,
    output logic          drv_oe,
    input  logic          ep0_evt,
    input  logic          inep_evt,
    input  logic          reg_we,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          susp_o,
    output logic          wake_o
);

    logic activity;
    logic j_to_k;
    logic count_en;
    logic idle_done;
    logic send_res;
    logic susp_clr;
    logic susp_set;
    logic res_set;

    usb_lp_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_i     (dp_i),
        .dm_i     (dm_i),
        .activity (activity),
        .j_to_k   (j_to_k)
    );

    usb_lp_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (count_en),
        .activity (activity),
        .done     (idle_done)
    );

    usb_lp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_done (idle_done),
        .j_to_k    (j_to_k),
        .send_res  (send_res),
        .susp_clr  (susp_clr),
        .count_en  (count_en),
        .susp_o    (susp_o),
        .wake_o    (wake_o),
        .drv_oe    (drv_oe),
        .dp_o      (dp_o),
        .dm_o      (dm_o),
        .susp_set  (susp_set),
        .res_set   (res_set)
    );

    usb_lp_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ep0_evt   (ep0_evt),
        .inep_evt  (inep_evt),
        .susp_set  (susp_set),
        .res_set   (res_set),
        .suspended (susp_o),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .send_res  (send_res),
        .susp_clr  (susp_clr)
    );

endmodule

// File: tb/usb_lp_ctrl_bench.sv
module usb_lp_ctrl_bench;

    localparam int IDLE = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp_i = 1'b0;
    logic       dm_i = 1'b1;
    logic       ep0_evt = 1'b0;
    logic       inep_evt = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dp_o, dm_o, drv_oe, irq, susp_o, wake_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    usb_lp_ctrl #(.IDLE_CYCLES(IDLE)) u_usb_lp_ctrl (
        .clk(clk), .rst_n(rst_n), .dp_i(dp_i), .dm_i(dm_i),
        .dp_o(dp_o), .dm_o(dm_o), .drv_oe(drv_oe),
        .ep0_evt(ep0_evt), .inep_evt(inep_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .susp_o(susp_o), .wake_o(wake_o)
    );

    // {ep0, inep, we, addr, wdata[7:0], exp_flags[7:0], exp_irq}
    localparam logic [20:0] VEC [0:7] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h04, 8'h02, 1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h03, 1'b1},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h03, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 8'h00, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic keepalive();
        dp_i = 1'b0; dm_i = 1'b0;
        tick(2);
        dp_i = 1'b0; dm_i = 1'b1;
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R10 reset state
        rd(1'b0, d); chk("R10 flags", d, 8'h00);
        rd(1'b1, d); chk("R10 ctrl", d, 8'h00);
        chk("R10 susp_o", susp_o, 0);
        chk("R10 drv_oe", drv_oe, 0);
        chk("R10 irq", irq, 0);
        chk("R10 wake_o", wake_o, 0);

        // R8 / R9 vector table
        for (int i = 0; i < 8; i++) begin
            ep0_evt   = VEC[i][20];
            inep_evt  = VEC[i][19];
            reg_we    = VEC[i][18];
            reg_addr  = VEC[i][17];
            reg_wdata = VEC[i][16:9];
            @(negedge clk);
            ep0_evt = 1'b0; inep_evt = 1'b0; reg_we = 1'b0;
            reg_addr = 1'b0; reg_wdata = 8'h00;
            #1;
            chk($sformatf("R8 flags vec%0d", i), reg_rdata, VEC[i][8:1]);
            chk($sformatf("R9 irq vec%0d", i), irq, VEC[i][0]);
        end

        // R7 writing 1 to suspend bit in ACTIVE
        keepalive();
        wr(1'b1, 8'h01);
        rd(1'b1, d); chk("R7 ctrl bit0", d[0], 0);
        chk("R7 susp_o", susp_o, 0);

        // R6 send-resume in ACTIVE
        wr(1'b1, 8'h02);
        tick(3);
        chk("R6 drv_oe", drv_oe, 0);
        wr(1'b1, 8'h00);

        // R2 keep-alives hold off suspend
        for (int k = 0; k < 4; k++) begin
            keepalive();
            tick(60);
        end
        chk("R2 no suspend", susp_o, 0);

        // R1 idle entry
        keepalive();
        tick(IDLE - 15);
        chk("R1 early", susp_o, 0);
        tick(30);
        chk("R1 susp_o", susp_o, 1);
        rd(1'b1, d); chk("R1 ctrl bit0", d[0], 1);
        rd(1'b0, d); chk("R1 flag bit2", d, 8'h04);
        chk("R1 irq", irq, 1);

        // R9 masking the suspend flag (ctrl bit3), keep bit0 set
        wr(1'b1, 8'h09);
        chk("R9 masked irq", irq, 0);
        wr(1'b1, 8'h01);
        chk("R9 unmasked irq", irq, 1);

        // R3 host resume
        dp_i = 1'b1; dm_i = 1'b0;
        tick(4);
        chk("R3 wake_o", wake_o, 1);
        rd(1'b0, d); chk("R3 flag bit3", d[3], 1);
        dp_i = 1'b0; dm_i = 1'b1;
        tick(3);
        chk("R3 wake held", wake_o, 1);

        // R4 clear suspend
        wr(1'b1, 8'h00);
        chk("R4 susp_o", susp_o, 0);
        chk("R4 wake_o", wake_o, 0);
        rd(1'b1, d); chk("R4 ctrl bit0", d[0], 0);
        wr(1'b0, 8'h0F);
        rd(1'b0, d); chk("R8 cleared", d, 8'h00);

        // R3 J-to-K in ACTIVE does not set resume
        dp_i = 1'b1; dm_i = 1'b0;
        tick(3);
        dp_i = 1'b0; dm_i = 1'b1;
        tick(2);
        rd(1'b0, d); chk("R3 active no resume", d[3], 0);

        // R5 device resume
        tick(IDLE + 10);
        chk("R5 suspended", susp_o, 1);
        wr(1'b1, 8'h03);
        tick(2);
        chk("R5 drv_oe", drv_oe, 1);
        chk("R5 dp_o", dp_o, 1);
        chk("R5 dm_o", dm_o, 0);
        wr(1'b1, 8'h01);
        tick(2);
        chk("R5 drive stop", drv_oe, 0);
        chk("R5 still suspended", susp_o, 1);
        wr(1'b1, 8'h00);
        chk("R4 back active", susp_o, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule